// File: doc/BRIEF.md
# Fault-Correcting Cipher Round Sequencer

This block is the controller for a cipher core that computes one permutation round per clock and keeps two complementary copies of its state. After a start pulse it first asks the datapath to precharge every state output to one. It then runs the initialization rounds, one associated-data block, one plaintext block and the finalization rounds, with a small round counter giving the round index inside each stage. The associated data and the plaintext are each a single 64-bit block.

Near the end of finalization the controller asks the datapath to write a snapshot of both state rails into storage. After the last round it spends one verify cycle looking at the tag comparison flag from the datapath. If that flag reports a mismatch, it restores the snapshot and recomputes the last round. If it does not, it spends one idle cycle instead. Both paths take the same number of cycles, so the time to completion does not show whether a correction took place. After that step it pulses `done`, and the tag is valid in that same cycle.

Top module: `cipher_seq_ctrl`

## Requirements
- R1: Stage `INIT` runs INIT_ROUNDS cycles, stages `AD` and `PT` run DATA_ROUNDS cycles each, and `FIN` runs FINAL_ROUNDS round cycles. In each round cycle `stateEn` is 1 and `roundIdx` counts up from 0 to the stage's round count minus 1.
- R2: A `start` seen while idle makes the next cycle a precharge cycle. In it `precharge` is 1, `stateEn` is 0 and `stage` is 0. `precharge` is high in no other cycle.
- R3: `stage` shows 0 when idle and during precharge, 1 for INIT, 2 for AD and 3 for PT. It shows 4 from the first finalization round until `done` has been shown.
- R4: `snapWr` is 1 in exactly one cycle per encryption. That cycle is the finalization round with `roundIdx` = FINAL_ROUNDS-2, which comes just before the last round.
- R5: The cycle after the last finalization round is a verify cycle. In it `stateEn` and `restore` are 0 and `roundIdx` holds FINAL_ROUNDS-1. `faultDetected` is sampled only in this cycle.
- R6: If `faultDetected` was 1 in the verify cycle, the next cycle has `restore` = 1 and `stateEn` = 1, with `roundIdx` = FINAL_ROUNDS-1.
- R7: If `faultDetected` was 0 in the verify cycle, the next cycle has `restore` = 0 and `stateEn` = 0, with `roundIdx` = FINAL_ROUNDS-1.
- R8: `done` is a one-cycle pulse in the cycle that follows the correction or no-correction cycle. This puts it INIT_ROUNDS+2·DATA_ROUNDS+FINAL_ROUNDS+3 clock edges after the edge that accepted `start`, whatever the fault flag was. `roundIdx` is 0 in that cycle.
- R9: `start` has no effect while an encryption is in progress, and `faultDetected` has no effect outside the verify cycle.
- R10: While reset is asserted (`rstN` = 0) and after it, before any start, all strobes and `done` are 0, and `roundIdx` and `stage` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts an encryption when the block is idle |
| faultDetected | input | 1 | Tag comparison mismatch flag from the datapath |
| done | output | 1 | One-cycle completion pulse; the tag is valid in this cycle |
| stage | output | 3 | Current stage code (0 none, 1 init, 2 ad, 3 pt, 4 fin) |
| roundIdx | output | CNT_W | Round index inside the current stage |
| stateEn | output | 1 | Enables the state registers to take a round result |
| precharge | output | 1 | Requests that all state outputs be set to one |
| snapWr | output | 1 | Requests a snapshot write of both rails |
| restore | output | 1 | Requests loading the snapshot before the last round is recomputed |

## Verification
The block is run once with a clean tag and once with a mismatch raised only in the verify cycle. Comparing the two shows that the correction path and the dummy path differ in their strobes but not in their latency. A third run holds the fault flag high in every cycle except the verify cycle, which shows that the flag is read only in that one cycle. A fourth run holds `start` high for the whole encryption, which shows that a busy controller neither restarts nor stretches the run.

// File: rtl/cipher_seq_pkg.sv
package cipher_seq_pkg;

  typedef enum logic [2:0] {
    STG_NONE = 3'd0,
    STG_INIT = 3'd1,
    STG_AD   = 3'd2,
    STG_PT   = 3'd3,
    STG_FIN  = 3'd4
  } stage_e;

  typedef enum logic [3:0] {
    C_IDLE, C_PRE, C_INIT, C_AD, C_PT, C_FIN,
    C_VER, C_CORR, C_NOCORR, C_DONE
  } ctrl_e;

  // strobes from control to the round counter
  typedef struct packed {
    logic   clr;
    logic   inc;
    stage_e stage;
  } ctrlStrobe_t;

endpackage

// File: rtl/cipher_seq_counter.sv
module cipher_seq_counter
  import cipher_seq_pkg::*;
#(
  parameter int CNT_W        = 4,
  parameter int INIT_ROUNDS  = 12,
  parameter int DATA_ROUNDS  = 6,
  parameter int FINAL_ROUNDS = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  output logic [CNT_W-1:0]  roundCnt,
  output logic              isLast,
  output logic              isPenult
);

  localparam logic [CNT_W:0] LIM_INIT  = (CNT_W+1)'(INIT_ROUNDS);
  localparam logic [CNT_W:0] LIM_DATA  = (CNT_W+1)'(DATA_ROUNDS);
  localparam logic [CNT_W:0] LIM_FINAL = (CNT_W+1)'(FINAL_ROUNDS);

  logic [CNT_W:0] limit;
  logic [CNT_W:0] cntWide;

  always_comb begin
    case (strobe.stage)
      STG_INIT: limit = LIM_INIT;
      STG_AD,
      STG_PT:   limit = LIM_DATA;
      STG_FIN:  limit = LIM_FINAL;
      default:  limit = LIM_INIT;
    endcase
  end

  assign cntWide  = {1'b0, roundCnt};
  assign isLast   = (cntWide == limit - 1'b1);
  assign isPenult = (cntWide == limit - 2'd2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            roundCnt <= '0;
    else if (strobe.clr)  roundCnt <= '0;
    else if (strobe.inc)  roundCnt <= roundCnt + 1'b1;
  end

  // R1: counter never wraps
  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.inc |-> (roundCnt != {CNT_W{1'b1}}));

  // R1: increment advances by exactly one
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.inc && !strobe.clr) |=> (roundCnt == $past(roundCnt) + CNT_W'(1)));

endmodule

// File: rtl/cipher_seq_fsm.sv
module cipher_seq_fsm
  import cipher_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         faultDetected,
  input  logic         isLast,
  input  logic         isPenult,
  output ctrlStrobe_t  strobe,
  output stage_e       stage,
  output logic         stateEn,
  output logic         precharge,
  output logic         snapWr,
  output logic         restore,
  output logic         done
);

  ctrl_e curState, nxtState;
  logic  clrCnt, incCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= C_IDLE;
    else       curState <= nxtState;
  end

  always_comb begin
    nxtState = curState;
    clrCnt   = 1'b0;
    incCnt   = 1'b0;
    case (curState)
      C_IDLE:   if (start) begin nxtState = C_PRE; clrCnt = 1'b1; end
      C_PRE:    nxtState = C_INIT;
      C_INIT:   if (isLast) begin nxtState = C_AD; clrCnt = 1'b1; end
                else incCnt = 1'b1;
      C_AD:     if (isLast) begin nxtState = C_PT; clrCnt = 1'b1; end
                else incCnt = 1'b1;
      C_PT:     if (isLast) begin nxtState = C_FIN; clrCnt = 1'b1; end
                else incCnt = 1'b1;
      C_FIN:    if (isLast) nxtState = C_VER;
                else incCnt = 1'b1;
      C_VER:    nxtState = faultDetected ? C_CORR : C_NOCORR;
      C_CORR,
      C_NOCORR: begin nxtState = C_DONE; clrCnt = 1'b1; end
      C_DONE:   nxtState = C_IDLE;
      default:  nxtState = C_IDLE;
    endcase
  end

  always_comb begin
    case (curState)
      C_INIT:  stage = STG_INIT;
      C_AD:    stage = STG_AD;
      C_PT:    stage = STG_PT;
      C_FIN, C_VER, C_CORR, C_NOCORR, C_DONE: stage = STG_FIN;
      default: stage = STG_NONE;
    endcase
  end

  assign strobe.clr   = clrCnt;
  assign strobe.inc   = incCnt;
  assign strobe.stage = stage;

  assign stateEn   = (curState == C_INIT) || (curState == C_AD) ||
                     (curState == C_PT)   || (curState == C_FIN) ||
                     (curState == C_CORR);
  assign precharge = (curState == C_PRE);
  assign snapWr    = (curState == C_FIN) && isPenult;
  assign restore   = (curState == C_CORR);
  assign done      = (curState == C_DONE);

  // R2: precharge is followed by the first init round
  p_pre_then_init_r2: assert property (@(posedge clk) disable iff (!rstN)
    precharge |=> (stage == STG_INIT && stateEn));

  // R4: snapshot cycle is directly followed by the last round
  p_snap_then_last_r4: assert property (@(posedge clk) disable iff (!rstN)
    snapWr |=> (curState == C_FIN && isLast));

  // R6: the step after verify follows the sampled flag
  p_fix_choice_r6: assert property (@(posedge clk) disable iff (!rstN)
    (curState == C_VER) |=> (restore == $past(faultDetected)));

  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: a busy controller never re-enters precharge
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (curState != C_IDLE) |=> !precharge);

endmodule

// File: rtl/cipher_seq_ctrl.sv
module cipher_seq_ctrl
  import cipher_seq_pkg::*;
#(
  parameter int CNT_W        = 4,
  parameter int INIT_ROUNDS  = 12,
  parameter int DATA_ROUNDS  = 6,
  parameter int FINAL_ROUNDS = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             faultDetected,
  output logic             done,
  output logic [2:0]       stage,
  output logic [CNT_W-1:0] roundIdx,
  output logic             stateEn,
  output logic             precharge,
  output logic             snapWr,
  output logic             restore
);

  ctrlStrobe_t cntStrobe;
  stage_e      stageInt;
  logic        isLast, isPenult;

  cipher_seq_fsm u_fsm (
    .clk           (clk),
    .rstN          (rstN),
    .start         (start),
    .faultDetected (faultDetected),
    .isLast        (isLast),
    .isPenult      (isPenult),
    .strobe        (cntStrobe),
    .stage         (stageInt),
    .stateEn       (stateEn),
    .precharge     (precharge),
    .snapWr        (snapWr),
    .restore       (restore),
    .done          (done)
  );

  cipher_seq_counter #(
    .CNT_W        (CNT_W),
    .INIT_ROUNDS  (INIT_ROUNDS),
    .DATA_ROUNDS  (DATA_ROUNDS),
    .FINAL_ROUNDS (FINAL_ROUNDS)
  ) u_cnt (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (cntStrobe),
    .roundCnt (roundIdx),
    .isLast   (isLast),
    .isPenult (isPenult)
  );

  assign stage = stageInt;

  // R10: reset leaves all strobes low
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stage == 3'd0 && !precharge) |-> (!stateEn && !snapWr && !restore && !done));

endmodule

// File: tb/cipher_seq_ctrl_tb.sv
module cipher_seq_ctrl_tb;

  localparam int CNT_W = 4;
  localparam int NI = 12;
  localparam int ND = 6;
  localparam int NF = 12;
  localparam int VER_STEP  = 1 + NI + 2*ND + NF;
  localparam int FIX_STEP  = VER_STEP + 1;
  localparam int DONE_STEP = VER_STEP + 2;
  localparam int LATENCY   = NI + 2*ND + NF + 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic faultDetected = 1'b0;
  logic done, stateEn, precharge, snapWr, restore;
  logic [2:0] stage;
  logic [CNT_W-1:0] roundIdx;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cipher_seq_ctrl #(.CNT_W(CNT_W), .INIT_ROUNDS(NI), .DATA_ROUNDS(ND),
                    .FINAL_ROUNDS(NF)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .faultDetected(faultDetected),
    .done(done), .stage(stage), .roundIdx(roundIdx), .stateEn(stateEn),
    .precharge(precharge), .snapWr(snapWr), .restore(restore)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  // behavioural reference: step -1 is idle, otherwise position in the run
  int  mStep = -1;
  bit  mFault = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) mStep = -1;
    else if (mStep < 0) begin
      if (start) mStep = 0;
    end else if (mStep == VER_STEP) begin
      mFault = faultDetected;
      mStep++;
    end else if (mStep == DONE_STEP) mStep = -1;
    else mStep++;
  end

  always @(negedge clk) begin
    int eStage, eIdx, eEn, ePre, eSnap, eRes, eDone;
    string enTag, resTag;
    cyc++;
    if (rstN) begin
      eStage = 0; eIdx = 0; eEn = 0; ePre = 0; eSnap = 0; eRes = 0; eDone = 0;
      enTag = "R1"; resTag = "R6";
      if (mStep == 0) ePre = 1;
      else if (mStep >= 1 && mStep <= NI) begin
        eStage = 1; eEn = 1; eIdx = mStep - 1;
      end else if (mStep > NI && mStep <= NI + ND) begin
        eStage = 2; eEn = 1; eIdx = mStep - 1 - NI;
      end else if (mStep > NI + ND && mStep <= NI + 2*ND) begin
        eStage = 3; eEn = 1; eIdx = mStep - 1 - NI - ND;
      end else if (mStep > NI + 2*ND && mStep < VER_STEP) begin
        eStage = 4; eEn = 1; eIdx = mStep - 1 - NI - 2*ND;
        eSnap = (eIdx == NF - 2) ? 1 : 0;
      end else if (mStep == VER_STEP) begin
        eStage = 4; eIdx = NF - 1; enTag = "R5"; resTag = "R5";
      end else if (mStep == FIX_STEP) begin
        eStage = 4; eIdx = NF - 1;
        eEn = mFault ? 1 : 0; eRes = mFault ? 1 : 0;
        enTag = mFault ? "R6" : "R7"; resTag = enTag;
      end else if (mStep == DONE_STEP) begin
        eStage = 4; eDone = 1;
      end
      chk("R3 stage", int'(stage), eStage);
      chk("R1 roundIdx", int'(roundIdx), eIdx);
      chk({enTag, " stateEn"}, int'(stateEn), eEn);
      chk("R2 precharge", int'(precharge), ePre);
      chk("R4 snapWr", int'(snapWr), eSnap);
      chk({resTag, " restore"}, int'(restore), eRes);
      chk("R8 done", int'(done), eDone);
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<=20000", cyc);
      summary();
    end
  end

  // one encryption; returns negedges from start to done inclusive
  task automatic runEnc(input bit faultAtVer, input bit faultOther,
                        input bit holdStart, output int lat);
    int n = 0;
    int snaps = 0;
    @(negedge clk);
    start = 1'b1;
    faultDetected = faultOther;
    forever begin
      @(negedge clk);
      n++;
      if (!holdStart) start = 1'b0;
      if (snapWr) snaps++;
      if (done) begin
        start = 1'b0;
        break;
      end
      faultDetected = (n == VER_STEP + 1) ? faultAtVer : faultOther;
      if (n > 200) break;
    end
    faultDetected = 1'b0;
    lat = n;
    chk("R4 snapshot count", snaps, 1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int latClean, latFault, latNoise, latHold;
    repeat (2) @(negedge clk);
    // R10: outputs during reset
    chk("R10 reset done", int'(done), 0);
    chk("R10 reset stateEn", int'(stateEn), 0);
    chk("R10 reset roundIdx", int'(roundIdx), 0);
    chk("R10 reset stage", int'(stage), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 idle precharge", int'(precharge), 0);

    runEnc(1'b0, 1'b0, 1'b0, latClean);
    chk("R8 latency clean", latClean, LATENCY + 1);
    runEnc(1'b1, 1'b0, 1'b0, latFault);
    chk("R8 latency fault", latFault, LATENCY + 1);
    chk("R8 equal latency", latFault, latClean);
    // R9: fault flag high everywhere except verify must not correct
    runEnc(1'b0, 1'b1, 1'b0, latNoise);
    chk("R9 latency fault elsewhere", latNoise, LATENCY + 1);
    // R9: start held high through the run
    runEnc(1'b1, 1'b0, 1'b1, latHold);
    chk("R9 latency start held", latHold, LATENCY + 1);
    chk("R9 idle after held start", int'(stage), 0);
    summary();
  end

endmodule